// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind the serial-bus front end of a byte-addressed nonvolatile memory. A write transaction opens with a start strobe that carries a 15-bit byte address. The upper nine bits pick one of 512 pages. The lower six bits set where the first byte lands within that 64-byte page. Data bytes then stream in over a valid/ready load channel. Each accepted byte is parked in a local page buffer and marked present. When the bus transaction ends, a commit strobe launches an internal write cycle. During that cycle only the marked positions are copied into the external array, and the block reports busy for a fixed, parameterized number of clock cycles.

An abort strobe throws the buffer away. The front end uses it when a repeated start turns the transaction into a read. A write-protect level sampled at commit suppresses the whole write cycle. A read request path hands array reads straight through to the array. The array is an external synchronous RAM that returns data one clock after the address is presented, and it starts out holding 0xFF in every byte.

Load channel flow control: `ld_ready` is high whenever no write cycle is running. A byte transfers on any rising clock edge where `ld_valid` and `ld_ready` are both high. While `ld_ready` is low, the offered byte is simply not taken, and the front end is expected to hold off acknowledging it on the bus.

Top module: `pgw_engine`

## Requirements
- R1: After reset `busy` is 0, `ld_ready` is 1 and `arr_we` is 0.
- R2: An accepted byte is stored at in-page position `ptr`. `ptr` is the low six bits of the last start address, advanced by one after every accepted byte. The page is the start address bits [14:6].
- R3: After position 63, the position wraps to 0 of the same page. A later byte at an already-loaded position replaces the earlier one.
- R4: A commit taken while idle, with at least one byte loaded and `wp` low, raises `busy` on the next clock edge. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R5: During the write cycle, `arr_we` is high only for positions loaded in this transaction. Each such position is written with its last loaded value, at address {page, position}. No other array byte changes.
- R6: A commit with `wp` high starts no write cycle: `busy` stays 0, no array write occurs, and the buffer is discarded.
- R7: A commit with no bytes loaded since the last start, abort or commit leaves `busy` at 0.
- R8: An abort taken while idle discards all loaded bytes. A following commit with no new loads writes nothing.
- R9: While `busy` is high, `ld_ready` is 0, and load, start, commit and abort strobes have no effect on the array or on the write-cycle length.
- R10: A start discards bytes loaded earlier but not yet committed.
- R11: Same-cycle rules: a byte loaded together with a start goes to the new start position; a byte loaded together with a commit is included in that commit; an abort together with a load or commit wins, so nothing is written.
- R12: `arr_raddr` follows `rd_addr` and `rd_data` follows `arr_rdata`, so a read returns the array byte one cycle after the address. Unwritten bytes read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect level, sampled at commit |
| tx_start | input | 1 | Opens a write transaction |
| tx_addr | input | 15 | Start byte address, taken with `tx_start` |
| ld_valid | input | 1 | Load byte offered |
| ld_ready | output | 1 | Load byte can be taken (no write cycle running) |
| ld_data | input | 8 | Load byte |
| commit | input | 1 | End of transaction; starts the write cycle |
| abort | input | 1 | Discard the buffer |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 15 | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | 15 | Read address from the front end |
| rd_data | output | 8 | Read data to the front end |
| arr_raddr | output | 15 | Array read address |
| arr_rdata | input | 8 | Array read data, one cycle after address |

## Verification
Several strobes can fall in the same cycle as a byte load. The bench drives a load together with a commit, a load together with a start, and a load together with an abort. It then judges the outcome by reading the page back through the read port and comparing it with a bench model, and by counting the cycles for which `busy` stays high. It also drives loads, starts and commits during a running write cycle. The write-cycle length must stay at `WR_CYCLES` and the page contents must stay unchanged.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W    = 15;
  localparam int PAGE_W    = 6;
  localparam int DATA_W    = 8;
  localparam int WR_CYCLES = 96;
endpackage

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAGE_W-1:0]     start_off,
  input  logic                  load,
  input  logic [DATA_W-1:0]     ld_data,
  input  logic                  clr,
  input  logic                  frozen,
  input  logic [PAGE_W-1:0]     rd_idx,
  output logic [(1<<PAGE_W)-1:0] mask_pre,
  output logic [(1<<PAGE_W)-1:0] mask,
  output logic [DATA_W-1:0]     rd_byte
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE-1:0]   mask_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_W-1:0] pos;
  logic [DATA_W-1:0] store [PAGE];

  always_comb begin
    pos      = start ? start_off : ptr_q;
    mask_pre = start ? '0 : mask_q;
    if (load) mask_pre[pos] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else begin
      mask_q <= clr ? '0 : mask_pre;
      if (load)       ptr_q <= pos + 1'b1;
      else if (start) ptr_q <= start_off;
    end
  end

  always_ff @(posedge clk) begin
    if (load) store[pos] <= ld_data;
  end

  assign mask    = mask_q;
  assign rd_byte = store[rd_idx];

  AST_FROZEN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (!load && !start)); // R9
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr) |=> (mask_q == $past(mask_q))); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !start) |=> (ptr_q == PAGE_W'($past(ptr_q) + 1'b1))); // R3
endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer #(
  parameter int WR_CYCLES = 96,
  localparam int CNT_W = $clog2(WR_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic [CNT_W-1:0] idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign done = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (go) busy_q <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign idx  = cnt_q;

  AST_BUSY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q); // R4
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R4
  AST_GO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy_q) |=> (busy_q && cnt_q == '0)); // R4
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine
  import pgw_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int PW  = PAGE_W,
  parameter int DW  = DATA_W,
  parameter int WRC = WR_CYCLES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp,
  input  logic          tx_start,
  input  logic [AW-1:0] tx_addr,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [DW-1:0] ld_data,
  input  logic          commit,
  input  logic          abort,
  output logic          busy,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] arr_raddr,
  input  logic [DW-1:0] arr_rdata
);
  localparam int PAGE  = 1 << PW;
  localparam int PGN_W = AW - PW;
  localparam int CNT_W = $clog2(WRC);

  logic             seq_busy, seq_done, go, clr;
  logic             load_g, start_g, commit_g, abort_g;
  logic [CNT_W-1:0] idx;
  logic [PAGE-1:0]  mask_pre, mask;
  logic [DW-1:0]    buf_byte;
  logic [PGN_W-1:0] page_q;
  logic [PW-1:0]    wpos;

  assign ld_ready = !seq_busy;
  assign load_g   = ld_valid && !seq_busy;
  assign start_g  = tx_start && !seq_busy;
  assign commit_g = commit   && !seq_busy;
  assign abort_g  = abort    && !seq_busy;
  assign go       = commit_g && !abort_g && !wp && (|mask_pre);
  assign clr      = abort_g || (commit_g && !go) || seq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (start_g) page_q <= tx_addr[AW-1:PW];
  end

  pgw_buffer #(.PAGE_W(PW), .DATA_W(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .start(start_g), .start_off(tx_addr[PW-1:0]),
    .load(load_g), .ld_data(ld_data), .clr(clr), .frozen(seq_busy),
    .rd_idx(wpos), .mask_pre(mask_pre), .mask(mask), .rd_byte(buf_byte)
  );

  pgw_sequencer #(.WR_CYCLES(WRC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(seq_busy), .idx(idx), .done(seq_done)
  );

  assign wpos      = idx[PW-1:0];
  assign arr_we    = seq_busy && (idx < CNT_W'(PAGE)) && mask[wpos];
  assign arr_waddr = {page_q, wpos};
  assign arr_wdata = buf_byte;
  assign busy      = seq_busy;

  assign arr_raddr = rd_addr;
  assign rd_data   = arr_rdata;

  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> seq_busy); // R5
  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wp && !seq_busy) |=> !seq_busy); // R6
  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !seq_busy && mask_pre == '0) |=> !seq_busy); // R7
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !seq_busy) |=> (!seq_busy && mask == '0)); // R8
endmodule

// File: tb/test_pgw_engine.sv
module test_pgw_engine;
  localparam int WRC = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp = 1'b0, tx_start = 1'b0, ld_valid = 1'b0, commit = 1'b0, abort = 1'b0;
  logic [14:0] tx_addr = '0, rd_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        ld_ready, busy, arr_we;
  logic [14:0] arr_waddr, arr_raddr;
  logic [7:0]  arr_wdata, rd_data;
  logic [7:0]  arr_rdata = 8'hFF;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit win = 0;
  logic [8:0] win_pg = '0;

  logic [7:0] arr_mem [int];
  logic [7:0] exp_mem [int];
  bit         pv [64];
  logic [7:0] pd [64];
  logic [8:0] mpg = '0;
  logic [5:0] mptr = '0;

  always #4 clk = ~clk;

  pgw_engine #(.WRC(WRC)) i_pgw_engine (
    .clk(clk), .rst_n(rst_n), .wp(wp), .tx_start(tx_start), .tx_addr(tx_addr),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data), .commit(commit),
    .abort(abort), .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  always @(posedge clk) begin
    if (arr_we) arr_mem[int'(arr_waddr)] = arr_wdata;
    arr_rdata <= arr_mem.exists(int'(arr_raddr)) ? arr_mem[int'(arr_raddr)] : 8'hFF;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      chk(win, "R6 write outside accepted cycle", 1, 0);
      chk(arr_waddr[14:6] == win_pg, "R5 write page", arr_waddr[14:6], win_pg);
    end
  end

  function automatic logic [7:0] rdexp(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  function automatic bit model(input bit st, input logic [14:0] a, input bit lv,
                               input logic [7:0] d, input bit cm, input bit ab, input bit w);
    logic [5:0] pos;
    bit any;
    pos = mptr;
    if (st) begin
      mpg = a[14:6];
      foreach (pv[i]) pv[i] = 0;
      pos = a[5:0];
      mptr = pos;
    end
    if (lv) begin
      pv[pos] = 1; pd[pos] = d; mptr = pos + 6'd1;
    end
    if (ab) begin
      foreach (pv[i]) pv[i] = 0;
      return 0;
    end
    if (!cm) return 0;
    any = 0;
    foreach (pv[i]) any |= pv[i];
    if (any && !w)
      foreach (pv[i]) if (pv[i]) exp_mem[int'({mpg, 6'(i)})] = pd[i];
    foreach (pv[i]) pv[i] = 0;
    return any && !w;
  endfunction

  task automatic drive(input bit st, input logic [14:0] a, input bit lv,
                       input logic [7:0] d, input bit cm, input bit ab, output bit go);
    @(negedge clk);
    if (lv) chk(ld_ready == 1'b1, "R9 ready when idle", ld_ready, 1);
    tx_start = st; tx_addr = a; ld_valid = lv; ld_data = d; commit = cm; abort = ab;
    go = model(st, a, lv, d, cm, ab, wp);
    if (go) begin win = 1; win_pg = mpg; end
  endtask

  task automatic wait_write(input bit go, input string req);
    int n = 0;
    repeat (WRC + 6) begin
      @(negedge clk);
      tx_start = 0; ld_valid = 0; commit = 0; abort = 0;
      if (busy) n++;
    end
    chk(n == (go ? WRC : 0), req, n, go ? WRC : 0);
    win = 0;
  endtask

  task automatic verify_page(input logic [8:0] pg, input string req);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); rd_addr = {pg, 6'(i)};
      @(negedge clk);
      chk(rd_data == rdexp(int'(rd_addr)), req, rd_data, rdexp(int'(rd_addr)));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit g;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ld_ready == 1, "R1 ready", ld_ready, 1);
    chk(arr_we == 0, "R1 we", arr_we, 0);
    rst_n = 1;
    @(negedge clk); rd_addr = 15'h1234;
    @(negedge clk); chk(rd_data == 8'hFF, "R12 erased", rd_data, 8'hFF);

    // R2 R3: start at offset 60, 70 loads wrap over the page
    drive(1, {9'd5, 6'd60}, 1, 8'h00, 0, 0, g);
    for (int i = 1; i < 70; i++) drive(0, '0, 1, 8'(i), 0, 0, g);
    drive(0, '0, 0, 0, 1, 0, g);
    wait_write(g, "R4 busy length");
    verify_page(9'd5, "R3 wrap contents");

    // R5 sparse load, R11 load with commit
    drive(1, {9'd7, 6'd10}, 1, 8'hA1, 0, 0, g);
    drive(0, '0, 1, 8'hA2, 1, 0, g);
    wait_write(g, "R11 load+commit busy");
    verify_page(9'd7, "R11 load+commit contents");

    // R11 load with start goes to new position; R10 earlier bytes dropped
    drive(1, {9'd9, 6'd3}, 1, 8'h11, 0, 0, g);
    drive(1, {9'd9, 6'd40}, 1, 8'h22, 0, 0, g);
    drive(0, '0, 0, 0, 1, 0, g);
    wait_write(g, "R10 busy");
    verify_page(9'd9, "R10 R11 start+load contents");

    // R11 abort with load, R8 then empty commit
    drive(1, {9'd12, 6'd0}, 1, 8'h33, 0, 0, g);
    drive(0, '0, 1, 8'h34, 0, 1, g);
    drive(0, '0, 0, 0, 1, 0, g);
    wait_write(g, "R8 abort then commit no busy");
    verify_page(9'd12, "R8 abort contents");

    // R7 empty commit
    drive(1, {9'd13, 6'd0}, 0, 0, 1, 0, g);
    wait_write(g, "R7 empty commit");

    // R6 write protect
    wp = 1;
    drive(1, {9'd14, 6'd2}, 1, 8'h44, 0, 0, g);
    drive(0, '0, 0, 0, 1, 0, g);
    wait_write(g, "R6 protected commit");
    wp = 0;
    verify_page(9'd14, "R6 protected contents");

    // R9 activity during busy
    drive(1, {9'd20, 6'd0}, 1, 8'h55, 1, 0, g);
    begin
      int n = 0;
      @(negedge clk);
      for (int k = 0; k < WRC + 6; k++) begin
        if (busy) n++;
        if (k < 10) begin
          chk(ld_ready == 0, "R9 ready low while busy", ld_ready, 0);
          tx_start = 1; tx_addr = {9'd20, 6'd8}; ld_valid = 1; ld_data = 8'h66; commit = 1;
        end else begin
          tx_start = 0; ld_valid = 0; commit = 0;
        end
        @(negedge clk);
      end
      chk(n == WRC, "R9 busy length unchanged", n, WRC);
      win = 0;
    end
    verify_page(9'd20, "R9 contents unchanged");

    // random transactions
    for (int t = 0; t < 20; t++) begin
      logic [14:0] a;
      int cnt;
      bit ab;
      a   = 15'($urandom);
      cnt = $urandom_range(0, 80);
      wp  = ($urandom_range(0, 3) == 0);
      ab  = ($urandom_range(0, 7) == 0);
      drive(1, a, cnt > 0, 8'($urandom), 0, 0, g);
      for (int i = 1; i < cnt; i++) drive(0, '0, 1, 8'($urandom), 0, 0, g);
      if (ab) drive(0, '0, 0, 0, 0, 1, g);
      drive(0, '0, 0, 0, 1, 0, g);
      wait_write(g, "R4 random busy");
      wp = 0;
      verify_page(a[14:6], "R5 random contents");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule